// File: doc/BRIEF.md
# Programmable Threshold Switch with Hysteresis

This block turns a stream of digitized field samples into one active-low digital output. It is meant for ferromagnetic target sensing. The output drops low while a tooth is present. It stays high over a gap, or when no target is near. The trip level is set by a 7-bit magnitude and a sign bit, which step a fixed base level up or down. The level at which the output returns high sits a constant distance below the trip level, and that distance does not depend on the code.

After supply is good, the block waits a fixed number of clock cycles and holds its output high during that wait. The first valid sample after the wait sets the output from the field level alone, with no dependence on earlier history. Later samples follow the hysteresis rule. Dropping the power-good input clears all state at once and forces the output high.

Top module: `tpos_switch`

## Requirements
- R1: While rst_ni is low, tooth_no is high (1); rst_ni going low forces tooth_no high without waiting for a clock edge.
- R2: For DELAY_CYC clock cycles after rst_ni rises, tooth_no stays high and every sample is ignored, whatever its value.
- R3: The first valid sample after the delay drives tooth_no low (0) if the sample is at or above the operate level.
- R4: The first valid sample after the delay drives tooth_no high (1) if the sample is below the operate level, even after an earlier run that left the output low.
- R5: While tooth_no is high, a valid sample at or above the operate level drives it low; a sample one unit below keeps it high.
- R6: While tooth_no is low, it stays low for samples at or above the release level and goes high for a sample below the release level.
- R7: The operate level is BASE + c*STEP, where c = +code_mag_i when code_neg_i = 0 and c = -code_mag_i when code_neg_i = 1.
- R8: The release level is always the operate level minus HYST, for any code.
- R9: code_neg_i only moves the operate level; a field above the level still drives tooth_no low.
- R10: Without a valid sample, tooth_no keeps its value. Each decision appears on tooth_no one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-good, active low, asynchronous clear |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed field sample |
| code_mag_i | input | CODE_W | Threshold code magnitude |
| code_neg_i | input | 1 | Code sign, 1 = negative |
| tooth_no | output | 1 | Active-low output, 0 = tooth present |

## Verification
The bench builds the block with a 16-bit sample, a 7-bit code, BASE 1000, STEP 4, HYST 40, and DELAY_CYC shortened to 8. With the short delay, the bench can send samples inside the power-on window and right after it, and it can repeat the power-on sequence in the middle of a run. With these values it can place samples exactly on and one unit off both levels, for positive codes, negative codes and the extreme negative code, so both boundaries and the sign handling are exercised.

// File: rtl/tpos_pkg.sv
package tpos_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } sw_state_e;
endpackage

// File: rtl/tpos_thresh.sv
module tpos_thresh #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 7,
  parameter int BASE     = 1000,
  parameter int STEP     = 4,
  parameter int HYST     = 40,
  localparam int THR_W   = SAMPLE_W + 2
) (
  input  logic [CODE_W-1:0]       code_mag_i,
  input  logic                    code_neg_i,
  output logic signed [THR_W-1:0] op_o,
  output logic signed [THR_W-1:0] rel_o
);
  localparam logic signed [THR_W-1:0] BASE_S = THR_W'(BASE);
  localparam logic signed [THR_W-1:0] STEP_S = THR_W'(STEP);
  localparam logic signed [THR_W-1:0] HYST_S = THR_W'(HYST);

  logic signed [THR_W-1:0] mag_x;
  logic signed [THR_W-1:0] code_s;

  always_comb begin
    mag_x  = {{(THR_W-CODE_W){1'b0}}, code_mag_i};
    code_s = code_neg_i ? -mag_x : mag_x;
    op_o   = BASE_S + code_s * STEP_S;
    rel_o  = op_o - HYST_S;
  end
endmodule

// File: rtl/tpos_por.sv
module tpos_por #(
  parameter int DELAY_CYC = 10000,
  localparam int CNT_W    = $clog2(DELAY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);

  assert_ready_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/tpos_decide.sv
module tpos_decide
  import tpos_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int THR_W   = SAMPLE_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ready_i,
  input  logic                    valid_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic signed [THR_W-1:0] op_i,
  input  logic signed [THR_W-1:0] rel_i,
  output logic                    tooth_o
);
  sw_state_e               state_q;
  logic signed [THR_W-1:0] samp_x;
  logic                    above_op;
  logic                    below_rel;

  assign samp_x    = {{2{sample_i[SAMPLE_W-1]}}, sample_i};
  assign above_op  = (samp_x >= op_i);
  assign below_rel = (samp_x < rel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      tooth_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT:  if (ready_i) state_q <= ST_PRIME;
        ST_PRIME: if (valid_i) begin
          // power-on decision from level alone
          tooth_o <= above_op;
          state_q <= ST_RUN;
        end
        ST_RUN:   if (valid_i) begin
          if (!tooth_o && above_op)      tooth_o <= 1'b1;
          else if (tooth_o && below_rel) tooth_o <= 1'b0;
        end
        default:  state_q <= ST_WAIT;
      endcase
    end
  end

  assert_high_before_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !tooth_o);
  assert_hold_no_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(tooth_o));
  assert_fall_needs_op_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tooth_o) |-> $past(valid_i && above_op));
  assert_release_below_rel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tooth_o) |-> $past(valid_i && below_rel));
endmodule

// File: rtl/tpos_switch.sv
module tpos_switch #(
  parameter int SAMPLE_W  = 16,
  parameter int CODE_W    = 7,
  parameter int BASE      = 1000,
  parameter int STEP      = 4,
  parameter int HYST      = 40,
  parameter int DELAY_CYC = 10000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CODE_W-1:0]   code_mag_i,
  input  logic                code_neg_i,
  output logic                tooth_no
);
  localparam int THR_W = SAMPLE_W + 2;

  logic signed [THR_W-1:0] op_lvl;
  logic signed [THR_W-1:0] rel_lvl;
  logic                    ready;
  logic                    tooth;

  tpos_thresh #(
    .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .BASE(BASE), .STEP(STEP), .HYST(HYST)
  ) u_thresh (
    .code_mag_i(code_mag_i),
    .code_neg_i(code_neg_i),
    .op_o      (op_lvl),
    .rel_o     (rel_lvl)
  );

  tpos_por #(.DELAY_CYC(DELAY_CYC)) u_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready)
  );

  tpos_decide #(.SAMPLE_W(SAMPLE_W)) u_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready),
    .valid_i (sample_valid_i),
    .sample_i(sample_i),
    .op_i    (op_lvl),
    .rel_i   (rel_lvl),
    .tooth_o (tooth)
  );

  assign tooth_no = ~tooth;
endmodule

// File: tb/tpos_switch_tb.sv
`timescale 1ns/1ps
module tpos_switch_tb;
  localparam int SW = 16, CW = 7, BASE = 1000, STEP = 4, HYST = 40, DLY = 8;

  typedef struct {
    logic  exp;
    string tag;
    int    smp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [CW-1:0] mag = '0;
  logic          neg = 1'b0;
  logic          out_n;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  item_t exp_q[$];

  // bench model state
  bit m_primed = 0;
  bit m_low    = 0;

  always #2.5 clk = ~clk;

  tpos_switch #(
    .SAMPLE_W(SW), .CODE_W(CW), .BASE(BASE), .STEP(STEP), .HYST(HYST), .DELAY_CYC(DLY)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(sample),
    .code_mag_i(mag), .code_neg_i(neg), .tooth_no(out_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tooth_no=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic int op_lvl();
    return BASE + (neg ? -int'(mag) : int'(mag)) * STEP;
  endfunction

  task automatic push_drive(input int s, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag; it.smp = s;
    exp_q.push_back(it);
    sample = SW'(s);
    valid  = 1'b1;
    @(negedge clk);
    valid  = 1'b0;
  endtask

  // sample during power-on window: always expect high
  task automatic send_pre(input int s, input string tag);
    push_drive(s, 1'b1, tag);
  endtask

  task automatic send(input int s, input string tag);
    int op, rel;
    op  = op_lvl();
    rel = op - HYST;
    if (!m_primed) begin
      m_low    = (s >= op);
      m_primed = 1;
    end else if (!m_low && s >= op) m_low = 1;
    else if (m_low && s < rel)      m_low = 0;
    push_drive(s, ~m_low, tag);
  endtask

  task automatic set_code(input int m, input logic n);
    @(negedge clk);
    mag = CW'(m);
    neg = n;
  endtask

  task automatic power_up();
    @(negedge clk);
    rst_n    = 1'b1;
    m_primed = 0;
    m_low    = 0;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && valid) begin
      #1;
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10: unexpected result, actual %b expected none", out_n);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(out_n, it.exp, $sformatf("%s (sample %0d)", it.tag, it.smp));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_n, 1'b1, "R1 reset state");

    power_up();
    send_pre(3000, "R2 window high");
    send_pre(1500, "R2 window high");
    send_pre(3000, "R2 window high");
    repeat (10) @(negedge clk);

    // code 0: op 1000, rel 960
    send(1000, "R3 first sample at op");
    send(961, "R6 above rel");
    send(960, "R6 at rel stays low");
    send(959, "R6 below rel");
    send(999, "R5 below op");
    send(1000, "R5 at op");
    repeat (5) @(negedge clk);
    check(out_n, 1'b0, "R10 hold without valid");

    // +32: op 1128, rel 1088
    set_code(32, 1'b0);
    send(1100, "R7 low kept above new rel");
    send(1088, "R8 at rel stays low");
    send(1087, "R8 below rel");
    send(1127, "R7 below op");
    send(1128, "R7 at op");

    // -8: op 968, rel 928
    set_code(8, 1'b1);
    send(927, "R8 below rel neg code");
    send(967, "R7 neg code below op");
    send(968, "R9 neg code at op low");
    send(928, "R8 neg at rel stays low");
    send(927, "R8 neg below rel");

    // -127: op 492, rel 452
    set_code(127, 1'b1);
    send(491, "R7 extreme below op");
    send(492, "R9 extreme at op low");
    send(452, "R8 extreme at rel");
    send(451, "R8 extreme below rel");
    send(-500, "R9 negative field high");
    send(3000, "R9 strong field low");

    // async power loss while low
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check(out_n, 1'b1, "R1 async clear");
    repeat (3) @(negedge clk);
    set_code(0, 1'b0);
    power_up();
    send_pre(3000, "R2 window after re-power");
    repeat (10) @(negedge clk);
    send(500, "R4 first sample below op");
    send(999, "R5 below op after power-up");
    send(1000, "R5 at op after power-up");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule